// File: doc/BRIEF.md
# Selectable Reference Frequency Divider

This block turns the crystal clock into the comparison tick of a frequency synthesis loop. A 4-bit selection code picks one reference frequency out of a fixed set. A crystal bit states which of two crystals drives the clock: 4.5 MHz or 7.2 MHz. The block works out the integer divide ratio for every pairing of crystal and code when it is elaborated. It then emits a one-cycle tick at the chosen reference rate. Two codes are not frequencies. They are commands that stop the loop, and one of them also asks the oscillator to stop. The clock input is taken to run at the selected crystal frequency.

A new setting arrives as one word on a valid/ready port. The block holds at most one word that has not yet taken effect, and `cfg_ready` stays low while that word waits. A word is accepted on a rising edge where both `cfg_valid` and `cfg_ready` are high. A sender facing a low `cfg_ready` must keep `cfg_valid` and the word steady until it is accepted. While the loop runs, an accepted word takes effect at the next tick boundary, so the interval in progress always ends at its old length. While the loop is stopped, an accepted word takes effect on the following edge.

Top module: `xtal_ref_divider`

## Requirements
- R1: With `cfg_xtal`=1 (7.2 MHz), `ref_tick` repeats every round(7 200 000 / f) clock cycles, where f is the frequency chosen by `cfg_code`. The codes are 4'd2 and 4'd3 → 25 kHz; 4'd13 → 15 kHz; 4'd0 → 100 kHz; 4'd6 and 4'd7 → 3.125 kHz; 4'd11 → 1 kHz; 4'd8 → 10 kHz; 4'd4 → 12.5 kHz; 4'd1 → 50 kHz; 4'd12 → 3 kHz; 4'd9 → 9 kHz; 4'd5 → 6.25 kHz; 4'd10 → 5 kHz.
- R2: With `cfg_xtal`=0 (4.5 MHz), the same code table applies, and the period is round(4 500 000 / f) clock cycles.
- R3: Code 4'd15 stops the loop. `loop_inhibit` is 1, `osc_stop` is 0 and no tick is produced.
- R4: Code 4'd14 stops the loop and requests an oscillator stop. `loop_inhibit` and `osc_stop` are both 1 and no tick is produced.
- R5: During reset and after it, until a word takes effect: `osc_hi_sel`=1 (7.2 MHz), `loop_inhibit`=1, `osc_stop`=0, `ref_tick`=0 and `cfg_ready`=1.
- R6: The port holds one pending word. `cfg_ready` drops in the cycle after an acceptance and rises again in the cycle after that word takes effect.
- R7: While ticks run, a pending word takes effect at the edge that ends a tick cycle. The next tick comes the new ratio later, and `osc_hi_sel` changes only there.
- R8: While the loop is stopped, a word accepted at edge A takes effect at edge A+1. Its first tick is visible in the cycle after edge A+R, where R is its ratio.
- R9: `ref_tick` is high for exactly one cycle per period and never appears outside the schedule above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Setting word offered |
| cfg_ready | output | 1 | Pending slot empty; word can be taken |
| cfg_code | input | 4 | Reference selection code |
| cfg_xtal | input | 1 | Crystal in use: 0 = 4.5 MHz, 1 = 7.2 MHz |
| ref_tick | output | 1 | One-cycle reference tick |
| loop_inhibit | output | 1 | Loop stopped (code 14 or 15 active) |
| osc_stop | output | 1 | Oscillator stop request (code 14 active) |
| osc_hi_sel | output | 1 | Active crystal selection given to the oscillator |

## Verification
The bench goes through every frequency code with both crystals. It predicts each tick to the exact cycle, so a ratio that is off by one, or rounded the wrong way, shows up as a mismatch at the first tick. Settings are changed in the middle of a run, just before a boundary. A design that applied a word at once would cut the running interval short or change `osc_hi_sel` early, and the scoreboard would see a tick that does not match. Each stop code is entered from a running loop and from a loop that is already stopped. A design that kept ticking, mixed up the two flags, or held back a word while stopped would produce unexpected ticks, wrong flags, or a late first tick.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  localparam int CODE_W = 4;

  typedef logic [CODE_W-1:0] ref_code_t;

  localparam ref_code_t CODE_HALT = 4'd14;  // loop stop plus oscillator stop
  localparam ref_code_t CODE_HOLD = 4'd15;  // loop stop only

  typedef struct packed {
    ref_code_t code;
    logic      xtal_hi;
  } ref_cfg_t;

  // Reference frequency in units of 1/8 Hz; zero marks a non-frequency code.
  function automatic longint unsigned ref_eighth_hz(int unsigned code);
    case (code)
      0:       return 64'd800000;
      1:       return 64'd400000;
      2, 3:    return 64'd200000;
      4:       return 64'd100000;
      5:       return 64'd50000;
      6, 7:    return 64'd25000;
      8:       return 64'd80000;
      9:       return 64'd72000;
      10:      return 64'd40000;
      11:      return 64'd8000;
      12:      return 64'd24000;
      13:      return 64'd120000;
      default: return 64'd0;
    endcase
  endfunction

  // Nearest-integer divide ratio; zero for the stop codes.
  function automatic int unsigned calc_ratio(longint unsigned xtal_hz, int unsigned code);
    longint unsigned f;
    f = ref_eighth_hz(code);
    if (f == 0) return 0;
    return int'((xtal_hz * 64'd8 + f / 64'd2) / f);
  endfunction

  function automatic int unsigned max_ratio(longint unsigned lo_hz, longint unsigned hi_hz);
    int unsigned m;
    m = 0;
    for (int c = 0; c < 16; c++) begin
      if (calc_ratio(lo_hz, c) > m) m = calc_ratio(lo_hz, c);
      if (calc_ratio(hi_hz, c) > m) m = calc_ratio(hi_hz, c);
    end
    return m;
  endfunction

  function automatic int unsigned min_ratio(longint unsigned lo_hz, longint unsigned hi_hz);
    int unsigned m;
    m = 32'hFFFF_FFFF;
    for (int c = 0; c < 16; c++) begin
      if (calc_ratio(lo_hz, c) != 0 && calc_ratio(lo_hz, c) < m) m = calc_ratio(lo_hz, c);
      if (calc_ratio(hi_hz, c) != 0 && calc_ratio(hi_hz, c) < m) m = calc_ratio(hi_hz, c);
    end
    return m;
  endfunction

endpackage

// File: rtl/refdiv_ratio_rom.sv
module refdiv_ratio_rom
  import refdiv_pkg::*;
#(
  parameter int unsigned XTAL_LO_HZ = 4_500_000,
  parameter int unsigned XTAL_HI_HZ = 7_200_000,
  parameter int          CNT_W      = 13
) (
  input  refdiv_pkg::ref_cfg_t sel,
  output logic [CNT_W-1:0]     ratio_m1
);

  localparam int ENTRIES = 2 * (1 << CODE_W);

  logic [CNT_W-1:0] tbl [ENTRIES];

  // One constant per crystal/code pair, folded at elaboration.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    localparam int unsigned RV = calc_ratio(
      (g >= (1 << CODE_W)) ? 64'(XTAL_HI_HZ) : 64'(XTAL_LO_HZ),
      g % (1 << CODE_W));
    assign tbl[g] = (RV == 0) ? '0 : CNT_W'(RV - 1);
  end

  assign ratio_m1 = tbl[{sel.xtal_hi, sel.code}];

endmodule

// File: rtl/refdiv_cfg_slot.sv
module refdiv_cfg_slot
  import refdiv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  refdiv_pkg::ref_cfg_t in_cfg,
  output logic                 in_ready,
  input  logic                 take,
  output logic                 pend_valid,
  output refdiv_pkg::ref_cfg_t pend_cfg
);

  assign in_ready = !pend_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_cfg   <= '{code: CODE_HOLD, xtal_hi: 1'b1};
    end else if (in_valid && in_ready) begin
      pend_valid <= 1'b1;
      pend_cfg   <= in_cfg;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/xtal_ref_divider.sv
module xtal_ref_divider
  import refdiv_pkg::*;
#(
  parameter int unsigned XTAL_LO_HZ = 4_500_000,
  parameter int unsigned XTAL_HI_HZ = 7_200_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_valid,
  output logic       cfg_ready,
  input  logic [3:0] cfg_code,
  input  logic       cfg_xtal,
  output logic       ref_tick,
  output logic       loop_inhibit,
  output logic       osc_stop,
  output logic       osc_hi_sel
);

  localparam int unsigned MAX_R = max_ratio(64'(XTAL_LO_HZ), 64'(XTAL_HI_HZ));
  localparam int          CNT_W = (MAX_R > 2) ? $clog2(MAX_R) : 1;

  ref_cfg_t         in_cfg, pend_cfg, act_cfg, rom_sel;
  logic             pend_valid, apply, inh, tick;
  logic [CNT_W-1:0] ratio_m1;

  assign in_cfg = '{code: cfg_code, xtal_hi: cfg_xtal};

  refdiv_cfg_slot u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (cfg_valid),
    .in_cfg     (in_cfg),
    .in_ready   (cfg_ready),
    .take       (apply),
    .pend_valid (pend_valid),
    .pend_cfg   (pend_cfg)
  );

  assign inh   = (act_cfg.code == CODE_HALT) || (act_cfg.code == CODE_HOLD);
  assign apply = pend_valid && (tick || inh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cfg <= '{code: CODE_HOLD, xtal_hi: 1'b1};
    end else if (apply) begin
      act_cfg <= pend_cfg;
    end
  end

  assign rom_sel = apply ? pend_cfg : act_cfg;

  refdiv_ratio_rom #(
    .XTAL_LO_HZ (XTAL_LO_HZ),
    .XTAL_HI_HZ (XTAL_HI_HZ),
    .CNT_W      (CNT_W)
  ) u_rom (
    .sel      (rom_sel),
    .ratio_m1 (ratio_m1)
  );

  refdiv_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (!inh),
    .load     (tick || apply),
    .load_val (ratio_m1),
    .tick     (tick)
  );

  assign ref_tick     = tick;
  assign loop_inhibit = inh;
  assign osc_stop     = (act_cfg.code == CODE_HALT);
  assign osc_hi_sel   = act_cfg.xtal_hi;

endmodule

// File: rtl/xtal_ref_divider_chk.sv
module xtal_ref_divider_chk
  import refdiv_pkg::*;
#(
  parameter int unsigned XTAL_LO_HZ = 4_500_000,
  parameter int unsigned XTAL_HI_HZ = 7_200_000
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_valid,
  input logic cfg_ready,
  input logic ref_tick,
  input logic loop_inhibit,
  input logic osc_stop,
  input logic osc_hi_sel
);

  localparam int unsigned MIN_R = min_ratio(64'(XTAL_LO_HZ), 64'(XTAL_HI_HZ));

  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (loop_inhibit) begin
      seen <= 1'b0;
    end else if (ref_tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end

  a_r3_no_tick_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |-> !loop_inhibit);

  a_r4_stop_implies_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> loop_inhibit);

  a_r6_ready_drops_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready) |=> !cfg_ready);

  a_r9_single_cycle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> !ref_tick);

  a_r9_min_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && seen) |-> (32'(gap) >= MIN_R - 1));

  a_r7_xtal_moves_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(osc_hi_sel) |-> $past(ref_tick || loop_inhibit));

endmodule

bind xtal_ref_divider xtal_ref_divider_chk #(
  .XTAL_LO_HZ (XTAL_LO_HZ),
  .XTAL_HI_HZ (XTAL_HI_HZ)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_valid    (cfg_valid),
  .cfg_ready    (cfg_ready),
  .ref_tick     (ref_tick),
  .loop_inhibit (loop_inhibit),
  .osc_stop     (osc_stop),
  .osc_hi_sel   (osc_hi_sel)
);

// File: tb/xtal_ref_divider_test.sv
module xtal_ref_divider_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic [3:0] cfg_code = 4'd0;
  logic       cfg_xtal = 1'b0;
  logic       cfg_ready, ref_tick, loop_inhibit, osc_stop, osc_hi_sel;

  int    cyc = 0;
  int    checks = 0;
  int    bad = 0;
  bit    done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  bit running = 1'b0;
  int last_t = 0;
  int cur_r = 0;

  xtal_ref_divider uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .cfg_ready    (cfg_ready),
    .cfg_code     (cfg_code),
    .cfg_xtal     (cfg_xtal),
    .ref_tick     (ref_tick),
    .loop_inhibit (loop_inhibit),
    .osc_stop     (osc_stop),
    .osc_hi_sel   (osc_hi_sel)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_ratio(logic [3:0] c, logic x);
    longint f_mhz, xt_mhz;
    case (c)
      4'd0:  f_mhz = 100_000_000;
      4'd1:  f_mhz = 50_000_000;
      4'd2:  f_mhz = 25_000_000;
      4'd3:  f_mhz = 25_000_000;
      4'd4:  f_mhz = 12_500_000;
      4'd5:  f_mhz = 6_250_000;
      4'd6:  f_mhz = 3_125_000;
      4'd7:  f_mhz = 3_125_000;
      4'd8:  f_mhz = 10_000_000;
      4'd9:  f_mhz = 9_000_000;
      4'd10: f_mhz = 5_000_000;
      4'd11: f_mhz = 1_000_000;
      4'd12: f_mhz = 3_000_000;
      default: f_mhz = 15_000_000;
    endcase
    xt_mhz = x ? 64'd7_200_000_000 : 64'd4_500_000_000;
    return int'((xt_mhz + f_mhz / 2) / f_mhz);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // Monitor: pops the expected tick times and compares them with the ticks seen.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++; bad++;
        $display("FAIL R9 missing tick: actual=none expected=%0d (%s)", exp_q[0], tag_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (ref_tick) begin
        if (exp_q.size() == 0) begin
          checks++; bad++;
          $display("FAIL R9 unexpected tick: actual=%0d expected=none", cyc);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(e == cyc, t, cyc, e);
        end
      end
    end
  end

  // Driver: offers one word at the current negedge; returns at the acceptance cycle.
  task automatic send_cfg(input logic [3:0] c, input logic x, output int acc);
    while (!cfg_ready) @(negedge clk);
    cfg_valid = 1'b1;
    cfg_code  = c;
    cfg_xtal  = x;
    acc = cyc + 1;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(cfg_ready == 1'b0, "R6", cfg_ready, 0);
  endtask

  task automatic play(input logic [3:0] c, input logic x, input int n);
    int acc, applied, r, first, old_last;
    bit was_running;
    was_running = running;
    old_last    = last_t;
    if (running) while (cyc != last_t - cur_r + 1) @(negedge clk);
    send_cfg(c, x, acc);
    applied = was_running ? old_last + 1 : acc + 1;
    if (was_running) begin
      while (cyc != old_last) @(negedge clk);
      chk(cfg_ready == 1'b0, "R6", cfg_ready, 0);
    end
    if (c[3:1] == 3'b111) begin
      while (cyc != applied + 1) @(negedge clk);
      chk(loop_inhibit == 1'b1, (c == 4'd14) ? "R4" : "R3", loop_inhibit, 1);
      chk(osc_stop == (c == 4'd14), (c == 4'd14) ? "R4" : "R3", osc_stop, int'(c == 4'd14));
      chk(osc_hi_sel == x, "R8", osc_hi_sel, x);
      chk(cfg_ready == 1'b1, "R6", cfg_ready, 1);
      running = 1'b0;
    end else begin
      r = exp_ratio(c, x);
      first = was_running ? old_last + r : acc + r;
      for (int k = 0; k < n; k++) begin
        exp_q.push_back(first + k * r);
        if (k == 0) tag_q.push_back(was_running ? "R7" : "R8");
        else        tag_q.push_back(x ? "R1" : "R2");
      end
      last_t  = first + (n - 1) * r;
      cur_r   = r;
      running = 1'b1;
      while (cyc != applied) @(negedge clk);
      chk(osc_hi_sel == x, was_running ? "R7" : "R8", osc_hi_sel, x);
      chk(loop_inhibit == 1'b0, "R8", loop_inhibit, 0);
      chk(cfg_ready == 1'b1, "R6", cfg_ready, 1);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; bad++;
      $display("FAIL R9 watchdog expired: actual=%0d expected=finished", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(osc_hi_sel == 1'b1, "R5", osc_hi_sel, 1);
    chk(loop_inhibit == 1'b1, "R5", loop_inhibit, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(osc_hi_sel == 1'b1, "R5", osc_hi_sel, 1);
    chk(loop_inhibit == 1'b1, "R5", loop_inhibit, 1);
    chk(osc_stop == 1'b0, "R5", osc_stop, 0);
    chk(ref_tick == 1'b0, "R5", ref_tick, 0);
    chk(cfg_ready == 1'b1, "R5", cfg_ready, 1);
    repeat (100) @(negedge clk);
    chk(ref_tick == 1'b0, "R5", ref_tick, 0);

    // 7.2 MHz crystal: every frequency code, switched at tick boundaries.
    play(4'd0, 1'b1, 4);
    play(4'd1, 1'b1, 3);
    play(4'd2, 1'b1, 2);
    play(4'd8, 1'b1, 2);
    play(4'd9, 1'b1, 2);
    play(4'd13, 1'b1, 2);
    play(4'd3, 1'b1, 2);
    play(4'd4, 1'b1, 2);
    play(4'd5, 1'b1, 2);
    play(4'd6, 1'b1, 2);
    play(4'd7, 1'b1, 2);
    play(4'd10, 1'b1, 2);
    play(4'd12, 1'b1, 2);
    play(4'd11, 1'b1, 2);
    play(4'd15, 1'b1, 0);
    repeat (300) @(negedge clk);
    chk(ref_tick == 1'b0, "R3", ref_tick, 0);
    play(4'd14, 1'b0, 0);
    repeat (300) @(negedge clk);
    chk(osc_stop == 1'b1, "R4", osc_stop, 1);

    // 4.5 MHz crystal, started from the stopped state.
    play(4'd0, 1'b0, 3);
    play(4'd1, 1'b0, 2);
    play(4'd2, 1'b0, 2);
    play(4'd3, 1'b0, 2);
    play(4'd4, 1'b0, 2);
    play(4'd5, 1'b0, 2);
    play(4'd6, 1'b0, 2);
    play(4'd7, 1'b0, 2);
    play(4'd8, 1'b0, 2);
    play(4'd9, 1'b0, 2);
    play(4'd10, 1'b0, 2);
    play(4'd11, 1'b0, 2);
    play(4'd12, 1'b0, 2);
    play(4'd13, 1'b0, 2);
    play(4'd2, 1'b1, 2);
    play(4'd14, 1'b1, 0);
    play(4'd15, 1'b0, 0);

    repeat (50) @(negedge clk);
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule